// File: doc/BRIEF.md
# Serial-Parallel Bit-Serial Multiplier

This block multiplies an unsigned multiplicand, loaded once in parallel, by a multiplier that is streamed in one bit per accepted cycle, least significant bit first. The product leaves the block as a serial stream in the same order, one bit per accepted input bit. To obtain the full double-width product, the caller follows the `WIDTH` multiplier bits with `WIDTH` zero bits. A flag on the first bit of each operation starts a new product, so operations may follow each other with no idle cycle in between.

The datapath is a row of `WIDTH` cells. Each cell forms the AND of its multiplicand bit with the current multiplier bit. It adds that term to the partial sum handed down from its upper neighbour and to its own stored carry, then keeps the new sum and carry in flip-flops. The lowest cell's sum flip-flop is the serial output. With `SYSTOLIC = 0`, every cell sees the incoming bit in the same cycle. With `SYSTOLIC = 1`, the bit and its flags ripple down the row through one register per cell, and each hop of the sum path gets one extra register, so no signal fans out to all cells. The added latency is `WIDTH - 1` cycles.

There are no state machines. The block has two operating variants, chosen by the `SYSTOLIC` parameter. The only transitions are the per-token cell updates described below.

Top module: `bsm_mult`

## Requirements
- R1: After the multiplicand is loaded, a stream of 2*WIDTH accepted bits produces 2*WIDTH product bits that, assembled LSB first, equal the unsigned product of the multiplicand and the multiplier. The stream is the multiplier LSB first, followed by WIDTH zeros, with the start flag on the first bit.
- R2: An accepted bit with `ser_first` high discards all accumulated sums and carries. Back-to-back operations with no idle cycle each give their own correct product.
- R3: While `ser_vld` is low, `ser_bit` and `ser_first` have no effect. Idle cycles inserted anywhere in an operation's stream leave its product unchanged.
- R4: With `SYSTOLIC = 0`, the product bit for an accepted input bit appears with `prod_vld` high one clock edge after that input was accepted. `prod_first` is high with product bit 0 only.
- R5: With `SYSTOLIC = 1`, products are identical to R1. Each product bit, including the `prod_first` marker, appears `WIDTH` clock edges after its input bit was accepted.
- R6: While and directly after reset, `prod_vld`, `prod_first` and `prod_bit` are 0.
- R7: `ld_mcand` is captured only on a clock edge with `ld_en` high. Changes on `ld_mcand` without `ld_en` do not alter later products.
- R8: Exactly one product bit is emitted per accepted input bit, in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Capture `ld_mcand` as the multiplicand |
| ld_mcand | input | WIDTH | Parallel multiplicand |
| ser_vld | input | 1 | Serial multiplier bit is valid this cycle |
| ser_first | input | 1 | Marks the first bit of an operation |
| ser_bit | input | 1 | Serial multiplier bit, LSB first |
| prod_vld | output | 1 | Product bit valid |
| prod_first | output | 1 | Product bit is bit 0 of a new product |
| prod_bit | output | 1 | Serial product bit, LSB first |

## Verification
Directed operands are used first: a zero multiplicand, all-ones times all-ones (every carry chain saturated), and single-bit operands at either end. These separate sum-forwarding errors from carry-feedback errors. Chains of back-to-back operations sharing one multiplicand, including a zero multiplier right after a dense one, show whether the start flag really clears leftover state. Streams with randomly placed idle cycles carrying random bit and flag values show that the gating covers every register, including the systolic forwarding stage. Both variants run on the same stimulus, so any difference in products or latency points at the retiming alone.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    // One serial token travelling with its control flags.
    typedef struct packed {
        logic bit_v;
        logic vld;
        logic first;
    } bsm_tok_t;

endpackage

// File: rtl/bsm_tok_chain.sv
module bsm_tok_chain
    import bsm_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter bit SYSTOLIC = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bsm_tok_t tok_in,
    output bsm_tok_t taps_o [WIDTH]
);

    assign taps_o[WIDTH-1] = tok_in;

    for (genvar i = 0; i < WIDTH - 1; i++) begin : g_tap
        if (SYSTOLIC) begin : g_reg
            bsm_tok_t tok_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tok_q <= '0;
                end else begin
                    tok_q <= taps_o[i+1];
                end
            end
            assign taps_o[i] = tok_q;
        end else begin : g_wire
            assign taps_o[i] = tok_in;
        end
    end

endmodule

// File: rtl/bsm_cell.sv
module bsm_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic first,
    input  logic xbit,
    input  logic a_bit,
    input  logic sum_in,
    output logic sum_q
);

    logic       carry_q;
    logic       pp;
    logic       fb_sum;
    logic       fb_carry;
    logic [1:0] total;

    assign pp       = a_bit & xbit;
    assign fb_sum   = first ? 1'b0 : sum_in;
    assign fb_carry = first ? 1'b0 : carry_q;
    assign total    = {1'b0, pp} + {1'b0, fb_sum} + {1'b0, fb_carry};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q   <= 1'b0;
            carry_q <= 1'b0;
        end else if (en) begin
            sum_q   <= total[0];
            carry_q <= total[1];
        end
    end

endmodule

// File: rtl/bsm_mult.sv
module bsm_mult
    import bsm_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter bit SYSTOLIC = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [WIDTH-1:0] ld_mcand,
    input  logic             ser_vld,
    input  logic             ser_first,
    input  logic             ser_bit,
    output logic             prod_vld,
    output logic             prod_first,
    output logic             prod_bit
);

    logic [WIDTH-1:0] mcand_q;
    bsm_tok_t         tok_in;
    bsm_tok_t         taps [WIDTH];
    logic             sum_q  [WIDTH];
    logic             sum_in [WIDTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
        end else if (ld_en) begin
            mcand_q <= ld_mcand;
        end
    end

    assign tok_in = '{bit_v: ser_bit, vld: ser_vld, first: ser_first};

    bsm_tok_chain #(
        .WIDTH    (WIDTH),
        .SYSTOLIC (SYSTOLIC)
    ) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .tok_in (tok_in),
        .taps_o (taps)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        if (i == WIDTH - 1) begin : g_top
            assign sum_in[i] = 1'b0;
        end else if (SYSTOLIC) begin : g_fwd
            // Holds the upper cell's previous-token sum for one extra hop.
            logic sum_d;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sum_d <= 1'b0;
                end else if (taps[i+1].vld) begin
                    sum_d <= sum_q[i+1];
                end
            end
            assign sum_in[i] = sum_d;
        end else begin : g_direct
            assign sum_in[i] = sum_q[i+1];
        end

        bsm_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (taps[i].vld),
            .first  (taps[i].first),
            .xbit   (taps[i].bit_v),
            .a_bit  (mcand_q[i]),
            .sum_in (sum_in[i]),
            .sum_q  (sum_q[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_vld   <= 1'b0;
            prod_first <= 1'b0;
        end else begin
            prod_vld   <= taps[0].vld;
            prod_first <= taps[0].vld & taps[0].first;
        end
    end

    assign prod_bit = sum_q[0];

endmodule

// File: rtl/bsm_mult_chk.sv
module bsm_mult_chk #(
    parameter int WIDTH    = 8,
    parameter bit SYSTOLIC = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_en,
    input logic [WIDTH-1:0] ld_mcand,
    input logic             ser_vld,
    input logic             ser_first,
    input logic [WIDTH-1:0] mcand_q,
    input logic             prod_vld,
    input logic             prod_first
);

    localparam int LAT = SYSTOLIC ? WIDTH : 1;

    logic [LAT-1:0] vld_h;
    logic [LAT-1:0] first_h;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_h   <= '0;
            first_h <= '0;
        end else begin
            vld_h   <= (vld_h << 1) | LAT'(ser_vld);
            first_h <= (first_h << 1) | LAT'(ser_vld & ser_first);
        end
    end

    // R8: one output per accepted input, after the fixed latency
    p_vld_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prod_vld == vld_h[LAT-1]);

    // R4 (R5 when systolic): start marker latency
    p_first_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prod_first == first_h[LAT-1]);

    p_first_has_vld_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prod_first |-> prod_vld);

    p_reset_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!prod_vld && !prod_first));

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (mcand_q == $past(ld_mcand)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(mcand_q));

endmodule

bind bsm_mult bsm_mult_chk #(
    .WIDTH    (WIDTH),
    .SYSTOLIC (SYSTOLIC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .ld_mcand   (ld_mcand),
    .ser_vld    (ser_vld),
    .ser_first  (ser_first),
    .mcand_q    (mcand_q),
    .prod_vld   (prod_vld),
    .prod_first (prod_first)
);

// File: tb/bsm_mult_tb_top.sv
module bsm_mult_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int PW = 2 * W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_en = 1'b0;
    logic [W-1:0] ld_mcand = '0;
    logic         ser_vld = 1'b0;
    logic         ser_first = 1'b0;
    logic         ser_bit = 1'b0;

    logic s_vld, s_first, s_bit;
    logic y_vld, y_first, y_bit;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int sent = 0;
    int got_s = 0;
    int got_y = 0;
    bit done = 1'b0;

    logic [PW-1:0] exp_s [$];
    logic [PW-1:0] exp_y [$];
    string         tag_s [$];
    string         tag_y [$];
    int            st_s  [$];
    int            st_y  [$];

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc++;

    bsm_mult #(.WIDTH(W), .SYSTOLIC(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_mcand(ld_mcand),
        .ser_vld(ser_vld), .ser_first(ser_first), .ser_bit(ser_bit),
        .prod_vld(s_vld), .prod_first(s_first), .prod_bit(s_bit)
    );

    bsm_mult #(.WIDTH(W), .SYSTOLIC(1'b1)) dut_sys_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_mcand(ld_mcand),
        .ser_vld(ser_vld), .ser_first(ser_first), .ser_bit(ser_bit),
        .prod_vld(y_vld), .prod_first(y_first), .prod_bit(y_bit)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] ref_prod(logic [W-1:0] a, logic [W-1:0] x);
        return PW'(a) * PW'(x);
    endfunction

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_vld   = 1'b0;
            ser_bit   = 1'($urandom);
            ser_first = 1'($urandom);
        end
    endtask

    task automatic run_op(logic [W-1:0] a, logic [W-1:0] x, bit reload, bit gaps, string tag);
        if (reload) begin
            @(negedge clk);
            ser_vld  = 1'b0;
            ld_en    = 1'b1;
            ld_mcand = a;
            @(negedge clk);
            ld_en    = 1'b0;
            ld_mcand = W'($urandom);  // R7: must not be captured
        end
        exp_s.push_back(ref_prod(a, x));
        exp_y.push_back(ref_prod(a, x));
        tag_s.push_back(tag);
        tag_y.push_back({"R5 ", tag});
        for (int j = 0; j < PW; j++) begin
            if (gaps && j > 0 && ($urandom % 3 == 0)) begin
                idle(1 + ($urandom % 2));  // R3 gaps
            end
            @(negedge clk);
            ser_vld   = 1'b1;
            ser_first = (j == 0);
            ser_bit   = (j < W) ? x[j] : 1'b0;
            if (j == 0) begin
                st_s.push_back(cyc);
                st_y.push_back(cyc);
            end
            sent++;
        end
    endtask

    logic [PW-1:0] acc_s = '0;
    int            idx_s = 0;
    always @(negedge clk) begin
        if (rst_n && s_vld) begin
            got_s++;
            if (s_first) begin
                idx_s = 0;
                acc_s = '0;
                if (st_s.size() > 0) chk("R4 latency", 64'(cyc - st_s.pop_front()), 64'd1);
            end
            if (idx_s < PW) acc_s[idx_s] = s_bit;
            idx_s++;
            if (idx_s == PW && exp_s.size() > 0) chk(tag_s.pop_front(), 64'(acc_s), 64'(exp_s.pop_front()));
        end
    end

    logic [PW-1:0] acc_y = '0;
    int            idx_y = 0;
    always @(negedge clk) begin
        if (rst_n && y_vld) begin
            got_y++;
            if (y_first) begin
                idx_y = 0;
                acc_y = '0;
                if (st_y.size() > 0) chk("R5 latency", 64'(cyc - st_y.pop_front()), 64'(W));
            end
            if (idx_y < PW) acc_y[idx_y] = y_bit;
            idx_y++;
            if (idx_y == PW && exp_y.size() > 0) chk(tag_y.pop_front(), 64'(acc_y), 64'(exp_y.pop_front()));
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R6 reset semisystolic", 64'({s_vld, s_first, s_bit}), 64'd0);
        chk("R6 reset systolic", 64'({y_vld, y_first, y_bit}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 after reset semisystolic", 64'({s_vld, s_first, s_bit}), 64'd0);
        chk("R6 after reset systolic", 64'({y_vld, y_first, y_bit}), 64'd0);

        run_op(8'h00, 8'hFF, 1, 0, "R1 zero multiplicand"); idle(W + 2);
        run_op(8'hFF, 8'hFF, 1, 0, "R1 all ones");           idle(W + 2);
        run_op(8'h01, 8'h01, 1, 0, "R1 unit operands");      idle(W + 2);
        run_op(8'h80, 8'h80, 1, 0, "R1 top bits only");      idle(W + 2);

        run_op(8'hA5, 8'hFF, 1, 0, "R2 lead op");
        run_op(8'hA5, 8'h3C, 0, 0, "R2 back-to-back");
        run_op(8'hA5, 8'h00, 0, 0, "R2 zero after dense");
        run_op(8'hA5, 8'hC9, 0, 0, "R2 third in chain");     idle(W + 2);

        run_op(8'hC3, 8'h9B, 1, 1, "R3 gaps");               idle(W + 2);
        run_op(8'hFF, 8'hFF, 1, 1, "R3 gaps all ones");      idle(W + 2);

        run_op(8'h5A, 8'hE7, 1, 0, "R7 load then garbage");
        run_op(8'h5A, 8'h71, 0, 1, "R7 hold without load");  idle(W + 2);

        for (int k = 0; k < 40; k++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rx;
            ra = W'($urandom);
            rx = W'($urandom);
            run_op(ra, rx, 1, ($urandom % 2) == 1, "R1 random");
            if ($urandom % 2 == 1) run_op(ra, W'($urandom), 0, 0, "R2 random chain");
            idle(W + 2);
        end

        idle(3 * W);
        chk("R8 count semisystolic", 64'(got_s), 64'(sent));
        chk("R8 count systolic", 64'(got_y), 64'(sent));
        chk("R8 queue drained", 64'(exp_s.size() + exp_y.size()), 64'd0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule